// File: doc/BRIEF.md
# Grouped Parallel Port Access Sequencer

This block drives an external byte-wide memory port. Read and write requests come in on two separate request channels. Each channel has its own small queue. The block never interleaves the two directions cycle by cycle. It drains one direction as a burst of back-to-back accesses, called a group. It then leaves the port idle for a fixed number of clock periods, the gap, before the next group starts. The gap is 8 periods in modes 1 and 2. It is 4 periods in every other mode.

Each access takes one clock period on the port. During a write the block drives the address and the data. During a read it drives the address, captures the returned byte at the end of the period and reports it on a response strobe. Two read/write indicator lines let the far side track the traffic:

- The first indicator flips on every write cycle.
- The second indicator flips whenever a new group runs in the opposite direction to the group before it.

A strobe line marks the cycles: low for reads, alternating for writes, and high while the port is idle.

Top module: `gport_sequencer`

## Requirements
- R1: After reset, the port is idle. The strobe is 1, the data enable is 0, both indicators are 1, the address is 0, no response is flagged, and both request ready outputs are 1.
- R2: A read cycle is never immediately followed by a write cycle, nor a write by a read. Within one direction, requests reach the port in the order they were accepted.
- R3: Between the last access of a group and the first access of the next group, the port stays idle for exactly 8 cycles when mode is 1 or 2. For any other mode value it stays idle for exactly 4 cycles, provided a request is waiting when the gap ends.
- R4: A group ends after its 16th access even if its queue still holds requests. A group also ends as soon as its queue runs empty. A new group of the same direction may follow after the gap.
- R5: When a group or gap finishes and both directions have pending requests, the direction opposite to the last group goes next. If only one direction is pending, that one goes, even if it repeats. The very first group after reset prefers reads.
- R6: In a read cycle, strobe is 0, data enable is 0, and the address equals the request address. The input byte is captured at the end of that cycle and presented on the response output with a one-cycle valid pulse in the following cycle.
- R7: In a write cycle, data enable is 1, and the data and address outputs equal the request. The strobe is 0 on the first write of a group and inverts on each further write of that group.
- R8: Indicator 1 inverts at the start of every write cycle and changes at no other time.
- R9: Indicator 2 inverts at the start of a group whose direction differs from the previous group. The first group after reset leaves it unchanged, so its first change after reset is high to low.
- R10: While the port is idle, the strobe is 1, the data enable is 0 (bus released), and the address holds its last driven value.
- R11: A request offered to an empty, idle sequencer is accepted at once and appears on the port in the second cycle after the cycle in which it was offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; one access per period |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Gap select: 1 or 2 give the long gap, other values the short gap |
| rd_req_valid | input | 1 | Read request offered |
| rd_req_ready | output | 1 | Read queue has room |
| rd_req_addr | input | 13 | Read address |
| wr_req_valid | input | 1 | Write request offered |
| wr_req_ready | output | 1 | Write queue has room |
| wr_req_addr | input | 13 | Write address |
| wr_req_data | input | 8 | Write byte |
| rd_rsp_valid | output | 1 | One-cycle pulse: captured read byte present |
| rd_rsp_data | output | 8 | Captured read byte |
| port_addr | output | 13 | Port address lines |
| port_rw1 | output | 1 | Indicator inverting per write cycle |
| port_rw2 | output | 1 | Indicator inverting per direction change between groups |
| port_strobe | output | 1 | Access strobe |
| port_data_out | output | 8 | Byte driven during writes |
| port_data_oe | output | 1 | Data bus drive enable |
| port_data_in | input | 8 | Byte returned by the device |

## Verification
The checks on the gap assume that `mode` is changed only while the port is idle and no group is pending. The stimulus changes mode only after each scenario has drained and the port has stayed quiet for many cycles. The checks also assume requests are offered only while ready is high. The bench never offers more requests than the 32-entry queues can hold at that point, so ready stays high throughout.

// File: rtl/gps_pkg.sv
// Shared types for the grouped port sequencer.
// Assumes: nothing beyond the standard language.
package gps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_GAP  = 2'd3
    } seq_state_e;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

endpackage

// File: rtl/gps_req_queue.sv
// Request queue: a circular buffer of DEPTH entries with a valid/ready push
// side and a combinational head. A pop is honoured in the cycle it is raised.
// Assumes: pop is raised only while not_empty is high.
module gps_req_queue #(
    parameter int WIDTH = 13,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    output logic             push_ready,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             not_empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push;

    assign push_ready = (count != CNT_W'(DEPTH));
    assign do_push    = push_valid && push_ready;
    assign not_empty  = (count != '0);
    assign head       = store[rd_ptr];

    // Write the pushed entry into the buffer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= push_data;
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0)); // R2

endmodule

// File: rtl/gps_group_ctrl.sv
// Group controller: decides, one cycle ahead, which queue feeds the port in
// the next cycle. It runs groups of one direction, closes a group at
// GROUP_MAX accesses or on an empty queue, and then holds a mode-dependent
// gap before the next group.
// Assumes: mode is stable while groups are in flight, and the gap
// parameters are at least 1.
module gps_group_ctrl
    import gps_pkg::*;
#(
    parameter int GROUP_MAX = 16,
    parameter int GAP_LONG  = 8,
    parameter int GAP_SHORT = 4,
    parameter int MODE_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              rd_avail,
    input  logic              wr_avail,
    output logic              issue_rd,
    output logic              issue_wr,
    output logic              grp_start,
    output logic              dir_flip
);
    localparam int CNT_W   = $clog2(GROUP_MAX + 1);
    localparam int GAP_MAX = (GAP_LONG > GAP_SHORT) ? GAP_LONG : GAP_SHORT;
    localparam int GAP_W   = $clog2(GAP_MAX + 1);

    seq_state_e       state, state_n;
    logic [CNT_W-1:0] grp_cnt, grp_cnt_n;
    logic [GAP_W-1:0] gap_cnt, gap_cnt_n, gap_len;
    dir_e             last_dir, last_dir_n;
    logic             have_grp, have_grp_n;
    logic             pick_rd, pick_wr, grp_full;

    // Gap length chosen by the mode input.
    always_comb begin
        if (mode == MODE_W'(1) || mode == MODE_W'(2)) begin
            gap_len = GAP_W'(GAP_LONG);
        end else begin
            gap_len = GAP_W'(GAP_SHORT);
        end
    end

    assign pick_rd  = rd_avail && (!wr_avail || last_dir == DIR_WR);
    assign pick_wr  = wr_avail && !pick_rd;
    assign grp_full = (grp_cnt == CNT_W'(GROUP_MAX));

    // Next-state decision and issue strobes.
    always_comb begin
        state_n    = state;
        grp_cnt_n  = grp_cnt;
        gap_cnt_n  = gap_cnt;
        last_dir_n = last_dir;
        have_grp_n = have_grp;
        issue_rd   = 1'b0;
        issue_wr   = 1'b0;
        grp_start  = 1'b0;
        dir_flip   = 1'b0;
        case (state)
            ST_RD: begin
                if (rd_avail && !grp_full) begin
                    issue_rd  = 1'b1;
                    grp_cnt_n = grp_cnt + 1'b1;
                end else begin
                    state_n   = ST_GAP;
                    gap_cnt_n = gap_len;
                end
            end
            ST_WR: begin
                if (wr_avail && !grp_full) begin
                    issue_wr  = 1'b1;
                    grp_cnt_n = grp_cnt + 1'b1;
                end else begin
                    state_n   = ST_GAP;
                    gap_cnt_n = gap_len;
                end
            end
            default: begin
                if (state == ST_GAP && gap_cnt != GAP_W'(1)) begin
                    gap_cnt_n = gap_cnt - 1'b1;
                end else if (pick_rd) begin
                    issue_rd   = 1'b1;
                    grp_start  = 1'b1;
                    dir_flip   = have_grp && (last_dir != DIR_RD);
                    state_n    = ST_RD;
                    grp_cnt_n  = CNT_W'(1);
                    last_dir_n = DIR_RD;
                    have_grp_n = 1'b1;
                end else if (pick_wr) begin
                    issue_wr   = 1'b1;
                    grp_start  = 1'b1;
                    dir_flip   = have_grp && (last_dir != DIR_WR);
                    state_n    = ST_WR;
                    grp_cnt_n  = CNT_W'(1);
                    last_dir_n = DIR_WR;
                    have_grp_n = 1'b1;
                end else begin
                    state_n = ST_IDLE;
                end
            end
        endcase
    end

    // Register the controller state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            grp_cnt  <= '0;
            gap_cnt  <= '0;
            last_dir <= DIR_WR;
            have_grp <= 1'b0;
        end else begin
            state    <= state_n;
            grp_cnt  <= grp_cnt_n;
            gap_cnt  <= gap_cnt_n;
            last_dir <= last_dir_n;
            have_grp <= have_grp_n;
        end
    end

    AST_GROUP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD || state == ST_WR) |-> (grp_cnt != '0 && grp_cnt <= CNT_W'(GROUP_MAX))); // R4
    AST_GROUP_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RD || state == ST_WR) && grp_full) |=> (state == ST_GAP)); // R4
    AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_rd && issue_wr)); // R2

endmodule

// File: rtl/gps_port_drv.sv
// Port driver: registers the port pins from the controller's issue strobes.
// It keeps the two indicator lines and the strobe, and captures read bytes.
// Assumes: issue_rd and issue_wr are never high together. Consecutive
// writes of one group are issued in consecutive cycles.
module gps_port_drv #(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int GAP_LONG  = 8,
    parameter int GAP_SHORT = 4,
    parameter int MODE_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              issue_rd,
    input  logic              issue_wr,
    input  logic              grp_start,
    input  logic              dir_flip,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] port_addr,
    output logic              port_rw1,
    output logic              port_rw2,
    output logic              port_strobe,
    output logic [DATA_W-1:0] port_data_out,
    output logic              port_data_oe,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int GAP_MAX = (GAP_LONG > GAP_SHORT) ? GAP_LONG : GAP_SHORT;
    localparam int QUIET_W = $clog2(GAP_MAX + 2);

    logic act_rd, act_wr;

    // Drive address, data, enable and strobe for the coming cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_addr     <= '0;
            port_data_out <= '0;
            port_data_oe  <= 1'b0;
            port_strobe   <= 1'b1;
            act_rd        <= 1'b0;
            act_wr        <= 1'b0;
        end else begin
            act_rd <= issue_rd;
            act_wr <= issue_wr;
            if (issue_rd) begin
                port_addr    <= rd_addr;
                port_data_oe <= 1'b0;
                port_strobe  <= 1'b0;
            end else if (issue_wr) begin
                port_addr     <= wr_addr;
                port_data_out <= wr_data;
                port_data_oe  <= 1'b1;
                port_strobe   <= grp_start ? 1'b0 : ~port_strobe;
            end else begin
                port_data_oe <= 1'b0;
                port_strobe  <= 1'b1;
            end
        end
    end

    // Indicator lines: one per write cycle, one per direction change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_rw1 <= 1'b1;
            port_rw2 <= 1'b1;
        end else begin
            if (issue_wr) port_rw1 <= ~port_rw1;
            if (dir_flip) port_rw2 <= ~port_rw2;
        end
    end

    // Capture the returned byte at the end of each read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= act_rd;
            if (act_rd) rsp_data <= data_in;
        end
    end

    // Checker state: idle cycles since the last access (saturating).
    logic               act_now, act_prev, seen_acc;
    logic [QUIET_W-1:0] quiet_cnt;
    logic [QUIET_W-1:0] gap_need;
    assign act_now  = act_rd || act_wr;
    assign gap_need = (mode == MODE_W'(1) || mode == MODE_W'(2)) ? QUIET_W'(GAP_LONG) : QUIET_W'(GAP_SHORT);

    // Track idle run length between accesses for the gap check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_prev  <= 1'b0;
            seen_acc  <= 1'b0;
            quiet_cnt <= '0;
        end else begin
            act_prev <= act_now;
            if (act_now) begin
                seen_acc  <= 1'b1;
                quiet_cnt <= '0;
            end else if (quiet_cnt != QUIET_W'(GAP_MAX + 1)) begin
                quiet_cnt <= quiet_cnt + 1'b1;
            end
        end
    end

    AST_GAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (act_now && !act_prev && seen_acc) |-> (quiet_cnt >= gap_need)); // R3
    AST_NO_MIX: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_rd && $past(act_wr)) && !(act_wr && $past(act_rd))); // R2
    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !act_now |-> (port_strobe && !port_data_oe && $stable(port_addr))); // R10
    AST_RW1_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(port_rw1) |-> act_wr); // R8
    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(act_rd)); // R6

endmodule

// File: rtl/gport_sequencer.sv
// Top of the grouped port sequencer: two request queues feed the group
// controller, which steers the port driver.
// Assumes: requests are offered only while the matching ready is high, and
// mode changes only while no group is pending.
module gport_sequencer #(
    parameter int ADDR_W      = 13,
    parameter int DATA_W      = 8,
    parameter int QUEUE_DEPTH = 32,
    parameter int GROUP_MAX   = 16,
    parameter int GAP_LONG    = 8,
    parameter int GAP_SHORT   = 4,
    parameter int MODE_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              rd_req_valid,
    output logic              rd_req_ready,
    input  logic [ADDR_W-1:0] rd_req_addr,
    input  logic              wr_req_valid,
    output logic              wr_req_ready,
    input  logic [ADDR_W-1:0] wr_req_addr,
    input  logic [DATA_W-1:0] wr_req_data,
    output logic              rd_rsp_valid,
    output logic [DATA_W-1:0] rd_rsp_data,
    output logic [ADDR_W-1:0] port_addr,
    output logic              port_rw1,
    output logic              port_rw2,
    output logic              port_strobe,
    output logic [DATA_W-1:0] port_data_out,
    output logic              port_data_oe,
    input  logic [DATA_W-1:0] port_data_in
);
    localparam int WR_W = ADDR_W + DATA_W;

    logic              rd_avail, wr_avail;
    logic              issue_rd, issue_wr, grp_start, dir_flip;
    logic [ADDR_W-1:0] rd_head;
    logic [WR_W-1:0]   wr_head;

    gps_req_queue #(.WIDTH(ADDR_W), .DEPTH(QUEUE_DEPTH)) i_rd_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (rd_req_valid),
        .push_ready (rd_req_ready),
        .push_data  (rd_req_addr),
        .pop        (issue_rd),
        .head       (rd_head),
        .not_empty  (rd_avail)
    );

    gps_req_queue #(.WIDTH(WR_W), .DEPTH(QUEUE_DEPTH)) i_wr_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (wr_req_valid),
        .push_ready (wr_req_ready),
        .push_data  ({wr_req_addr, wr_req_data}),
        .pop        (issue_wr),
        .head       (wr_head),
        .not_empty  (wr_avail)
    );

    gps_group_ctrl #(
        .GROUP_MAX (GROUP_MAX),
        .GAP_LONG  (GAP_LONG),
        .GAP_SHORT (GAP_SHORT),
        .MODE_W    (MODE_W)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .rd_avail  (rd_avail),
        .wr_avail  (wr_avail),
        .issue_rd  (issue_rd),
        .issue_wr  (issue_wr),
        .grp_start (grp_start),
        .dir_flip  (dir_flip)
    );

    gps_port_drv #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .GAP_LONG  (GAP_LONG),
        .GAP_SHORT (GAP_SHORT),
        .MODE_W    (MODE_W)
    ) i_drv (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode          (mode),
        .issue_rd      (issue_rd),
        .issue_wr      (issue_wr),
        .grp_start     (grp_start),
        .dir_flip      (dir_flip),
        .rd_addr       (rd_head),
        .wr_addr       (wr_head[WR_W-1:DATA_W]),
        .wr_data       (wr_head[DATA_W-1:0]),
        .data_in       (port_data_in),
        .port_addr     (port_addr),
        .port_rw1      (port_rw1),
        .port_rw2      (port_rw2),
        .port_strobe   (port_strobe),
        .port_data_out (port_data_out),
        .port_data_oe  (port_data_oe),
        .rsp_valid     (rd_rsp_valid),
        .rsp_data      (rd_rsp_data)
    );

endmodule

// File: tb/test_gport_sequencer.sv
`timescale 1ns/100ps
module test_gport_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'd1;
    logic        rd_req_valid = 1'b0, wr_req_valid = 1'b0;
    logic        rd_req_ready, wr_req_ready;
    logic [12:0] rd_req_addr = '0, wr_req_addr = '0;
    logic [7:0]  wr_req_data = '0;
    logic        rd_rsp_valid;
    logic [7:0]  rd_rsp_data;
    logic [12:0] port_addr;
    logic        port_rw1, port_rw2, port_strobe, port_data_oe;
    logic [7:0]  port_data_out, port_data_in;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Log of port activity per negedge: kind 0 idle, 1 read, 2 write.
    int          k_log  [1024];
    logic [12:0] a_log  [1024];
    logic [7:0]  d_log  [1024];
    logic        s_log  [1024];
    logic        w1_log [1024];
    logic        w2_log [1024];
    logic        rv_log [1024];
    logic [7:0]  rd_log [1024];

    always #2.5 clk = ~clk;

    // Device model: returns a byte derived from the address.
    assign port_data_in = port_addr[7:0] ^ 8'hA5;

    gport_sequencer i_gport_sequencer (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready), .wr_req_addr(wr_req_addr),
        .wr_req_data(wr_req_data), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .port_addr(port_addr), .port_rw1(port_rw1), .port_rw2(port_rw2),
        .port_strobe(port_strobe), .port_data_out(port_data_out),
        .port_data_oe(port_data_oe), .port_data_in(port_data_in)
    );

    always @(negedge clk) begin
        k_log[cyc % 1024]  <= port_data_oe ? 2 : (!port_strobe ? 1 : 0);
        a_log[cyc % 1024]  <= port_addr;
        d_log[cyc % 1024]  <= port_data_out;
        s_log[cyc % 1024]  <= port_strobe;
        w1_log[cyc % 1024] <= port_rw1;
        w2_log[cyc % 1024] <= port_rw2;
        rv_log[cyc % 1024] <= rd_rsp_valid;
        rd_log[cyc % 1024] <= rd_rsp_data;
        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic offer(input bit rv, input logic [12:0] ra, input bit wv,
                         input logic [12:0] wa, input logic [7:0] wd, output int idx);
        @(negedge clk); #1;
        idx = cyc - 1;
        rd_req_valid = rv; rd_req_addr = ra;
        wr_req_valid = wv; wr_req_addr = wa; wr_req_data = wd;
    endtask

    task automatic release_inputs();
        @(negedge clk); #1;
        rd_req_valid = 1'b0;
        wr_req_valid = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        chk_eq("R1 strobe", port_strobe, 1);
        chk_eq("R1 oe", port_data_oe, 0);
        chk_eq("R1 rw1", port_rw1, 1);
        chk_eq("R1 rw2", port_rw2, 1);
        chk_eq("R1 addr", port_addr, 0);
        chk_eq("R1 rsp_valid", rd_rsp_valid, 0);
        chk_eq("R1 ready", {rd_req_ready, wr_req_ready}, 2'b11);
    endtask

    // Single read from idle: latency, read pins, capture, idle after.
    task automatic t_single_read();
        int i0;
        mode = 3'd1;
        offer(1'b1, 13'h123, 1'b0, '0, '0, i0);
        release_inputs();
        settle(12);
        chk_eq("R11 latency kind", k_log[(i0+1)%1024], 0);
        chk_eq("R11 read appears", k_log[(i0+2)%1024], 1);
        chk_eq("R6 read addr", a_log[(i0+2)%1024], 13'h123);
        chk_eq("R6 rsp valid", rv_log[(i0+3)%1024], 1);
        chk_eq("R6 rsp data", rd_log[(i0+3)%1024], 8'h23 ^ 8'hA5);
        chk_eq("R6 rsp pulse", rv_log[(i0+4)%1024], 0);
        chk_eq("R10 idle after", k_log[(i0+3)%1024], 0);
        chk_eq("R10 addr held", a_log[(i0+5)%1024], 13'h123);
        chk_eq("R10 strobe idle", s_log[(i0+5)%1024], 1);
        chk_eq("R9 first group no flip", w2_log[(i0+2)%1024], 1);
    endtask

    // Mode 1: three reads and three writes offered together.
    task automatic t_mixed_long_gap();
        int i0, tmp, base;
        logic w1_before;
        mode = 3'd1;
        offer(1'b1, 13'h040, 1'b1, 13'h080, 8'h10, i0);
        offer(1'b1, 13'h041, 1'b1, 13'h081, 8'h11, tmp);
        offer(1'b1, 13'h042, 1'b1, 13'h082, 8'h12, tmp);
        release_inputs();
        settle(25);
        w1_before = w1_log[(i0+1)%1024];
        for (int k = 0; k < 3; k++) begin
            base = (i0 + 2 + k) % 1024;
            chk_eq("R5 write group first", k_log[base], 2);
            chk_eq("R7 write addr", a_log[base], 13'h080 + k);
            chk_eq("R7 write data", d_log[base], 8'h10 + k);
            chk_eq("R7 strobe phase", s_log[base], k % 2);
            chk_eq("R8 rw1 toggles", w1_log[base], (k % 2 == 0) ? !w1_before : w1_before);
        end
        chk_eq("R9 rw2 high to low", w2_log[(i0+2)%1024], 0);
        for (int k = 0; k < 8; k++) begin
            chk_eq("R3 long gap idle", k_log[(i0+5+k)%1024], 0);
            chk_eq("R10 gap addr", a_log[(i0+5+k)%1024], 13'h082);
        end
        chk_eq("R8 rw1 steady in gap", w1_log[(i0+12)%1024], !w1_before);
        for (int k = 0; k < 3; k++) begin
            chk_eq("R3 read group after gap", k_log[(i0+13+k)%1024], 1);
            chk_eq("R2 read order", a_log[(i0+13+k)%1024], 13'h040 + k);
            chk_eq("R6 rsp data", rd_log[(i0+14+k)%1024], (8'h40 + k) ^ 8'hA5);
        end
        chk_eq("R9 rw2 back up", w2_log[(i0+13)%1024], 1);
        chk_eq("R4 empty ends group", k_log[(i0+16)%1024], 0);
    endtask

    // Mode 3: two writes, then a read arriving during the writes.
    task automatic t_short_gap();
        int j0, tmp;
        mode = 3'd3;
        offer(1'b0, '0, 1'b1, 13'h1F00, 8'hC3, j0);
        offer(1'b1, 13'h0777, 1'b1, 13'h1F01, 8'h3C, tmp);
        release_inputs();
        settle(20);
        chk_eq("R2 write 0", k_log[(j0+2)%1024], 2);
        chk_eq("R2 write 1", k_log[(j0+3)%1024], 2);
        chk_eq("R7 second write data", d_log[(j0+3)%1024], 8'h3C);
        for (int k = 0; k < 4; k++) begin
            chk_eq("R3 short gap idle", k_log[(j0+4+k)%1024], 0);
        end
        chk_eq("R3 read after 4", k_log[(j0+8)%1024], 1);
        chk_eq("R5 read addr", a_log[(j0+8)%1024], 13'h0777);
    endtask

    // Mode 4: twenty reads streamed in, group capped at 16.
    task automatic t_group_limit();
        int k0, tmp;
        mode = 3'd4;
        offer(1'b1, 13'h0200, 1'b0, '0, '0, k0);
        for (int m = 1; m < 20; m++) begin
            offer(1'b1, 13'h0200 + m, 1'b0, '0, '0, tmp);
        end
        release_inputs();
        settle(20);
        for (int m = 0; m < 16; m++) begin
            chk_eq("R4 first group read", k_log[(k0+2+m)%1024], 1);
            chk_eq("R2 order", a_log[(k0+2+m)%1024], 13'h0200 + m);
        end
        for (int m = 0; m < 4; m++) begin
            chk_eq("R4 cap gap", k_log[(k0+18+m)%1024], 0);
        end
        for (int m = 0; m < 4; m++) begin
            chk_eq("R5 same dir resumes", k_log[(k0+22+m)%1024], 1);
            chk_eq("R2 order tail", a_log[(k0+22+m)%1024], 13'h0210 + m);
        end
        chk_eq("R9 no flip same dir", w2_log[(k0+22)%1024], 1);
        chk_eq("R6 last rsp", rd_log[(k0+26)%1024], 8'h13 ^ 8'hA5);
    endtask

    // Mode 2: read then a write arriving during the read.
    task automatic t_mode2();
        int n0, tmp;
        mode = 3'd2;
        offer(1'b1, 13'h0ABC, 1'b0, '0, '0, n0);
        offer(1'b0, '0, 1'b1, 13'h0DEF, 8'h99, tmp);
        release_inputs();
        settle(20);
        chk_eq("R6 read", k_log[(n0+2)%1024], 1);
        for (int k = 0; k < 8; k++) begin
            chk_eq("R3 mode2 gap", k_log[(n0+3+k)%1024], 0);
        end
        chk_eq("R3 write after 8", k_log[(n0+11)%1024], 2);
        chk_eq("R7 single write strobe", s_log[(n0+11)%1024], 0);
        chk_eq("R9 rw2 flips", w2_log[(n0+11)%1024], !w2_log[(n0+10)%1024]);
        chk_eq("R10 released", k_log[(n0+12)%1024], 0);
    endtask

    initial begin
        t_reset();
        t_single_read();
        settle(10);
        t_mixed_long_gap();
        settle(10);
        t_short_gap();
        settle(10);
        t_group_limit();
        settle(10);
        t_mode2();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule